// File: doc/BRIEF.md
# Firmware Configuration Item Port

This block lets boot firmware fetch configuration items held in a small on-chip table. Firmware picks an item by writing a 16-bit key. It then pulls the item's bytes out, one access after another, through a data register. The block keeps the current selection and a byte offset inside the selected item. A read of several bytes is packed so that the earliest item byte lands in the most significant position of the returned bytes. When the item ends part way through a read, the remaining low bytes come back as zero.

Two access styles are offered side by side. The first is a combined port in the style of legacy port I/O, where the access width picks the function. The second is a pair of separate registers: a control register for the key and a data register for the bytes. The table has two banks: a common bank and an architecture-local bank. The table's contents, both lengths and bytes, are loaded through a preload write port before firmware runs. After reset the key is zero. Entry zero holds a four-byte signature.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selection is key 0 with offset 0. Entry 0 of the common bank has length 4 and holds the bytes 0x51, 0x45, 0x4D, 0x55, so the first four byte reads return them in that order.
- R2: Every accepted key write sets the byte offset to zero, whether the key is valid or not. Selecting the same key again restarts the item from its first byte.
- R3: Key bit 15 selects the bank (1 = architecture-local). Bits 13:0 form the entry index. Bit 14 is ignored. An index at or above LIMIT (FIXED_ITEMS + FILE_SLOTS, 8 by default) marks the selection invalid.
- R4: A read of N bytes (1 to RD_BYTES) returns successive item bytes in rd_data[8N-1:0], the first byte most significant. The offset advances by the number of item bytes delivered.
- R5: When fewer than N item bytes remain, the delivered bytes occupy the upper part of the N-byte field and the lower bytes are zero.
- R6: A read returns zero and leaves the offset unchanged in three cases: the selection is invalid, the entry's length is 0, or the offset has reached the length.
- R7: On the combined port, a size-1 read is a data read and a size-1 write is accepted with no effect. A size-2 write loads the key from cmb_wdata. Any other size, and a size-2 read, is rejected.
- R8: The control register accepts only size-2 writes. The data register accepts an access only at dat_addr 0 with a size from 1 to RD_BYTES. Writes accepted by the data register have no effect.
- R9: A rejected access changes no state and pulses rej for one cycle. If it was a read, rd_valid pulses and rd_data is zero.
- R10: When several interfaces are active in one cycle, only one is served: the combined port first, then the control register, then the data register. The others are dropped without a rejection.
- R11: Results are registered. rd_valid, rd_data and rej appear in the cycle after the access. The preload port writes an entry's length (pl_len_we) or one of its bytes (pl_byte_we) at the addressed bank and entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmb_valid | input | 1 | Combined port access strobe |
| cmb_write | input | 1 | Combined port: 1 = write |
| cmb_size | input | SZ_W | Combined port access size in bytes |
| cmb_wdata | input | 16 | Combined port write data (key) |
| ctl_valid | input | 1 | Control register access strobe |
| ctl_write | input | 1 | Control register: 1 = write |
| ctl_size | input | SZ_W | Control register access size in bytes |
| ctl_wdata | input | 16 | Control register write data (key) |
| dat_valid | input | 1 | Data register access strobe |
| dat_write | input | 1 | Data register: 1 = write |
| dat_addr | input | 3 | Byte offset of the data register access |
| dat_size | input | SZ_W | Data register access size in bytes |
| pl_byte_we | input | 1 | Preload: write one item byte |
| pl_len_we | input | 1 | Preload: write an item length |
| pl_bank | input | 1 | Preload bank |
| pl_entry | input | IDX_W | Preload entry index |
| pl_addr | input | BA_W | Preload byte position within the item |
| pl_data | input | 8 | Preload byte value |
| pl_len | input | OFF_W | Preload length value |
| rd_valid | output | 1 | Read result valid, one cycle after the read |
| rd_data | output | 8*RD_BYTES | Read result, packed in the low N bytes |
| rej | output | 1 | Pulse: the previous access was rejected |

## Verification
Several properties are checked on every cycle. A key write leaves the offset at zero. The offset never passes the maximum item length. A rejected access leaves the offset untouched and returns zero. Any read made while the selection is invalid returns zero. Size-2 combined reads and control-register reads always raise the rejection pulse. Other behaviours can only be shown by the directed scenarios, because they depend on table contents loaded earlier. These include the byte ordering and right-side zero fill, bank selection through key bit 15, the ignored key bit 14, and the signature after reset. The same holds for the serving order between interfaces active together, and for the fact that ignored writes do not disturb the stream.

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
  parameter int FIXED_ITEMS = 4,
  parameter int FILE_SLOTS  = 4,
  parameter int MAX_LEN     = 16,
  parameter int RD_BYTES    = 8,
  localparam int LIMIT  = FIXED_ITEMS + FILE_SLOTS,
  localparam int IDX_W  = $clog2(LIMIT),
  localparam int OFF_W  = $clog2(MAX_LEN + 1),
  localparam int BA_W   = $clog2(MAX_LEN),
  localparam int SZ_W   = $clog2(RD_BYTES + 1),
  localparam int DW     = 8 * RD_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmb_valid,
  input  logic             cmb_write,
  input  logic [SZ_W-1:0]  cmb_size,
  input  logic [15:0]      cmb_wdata,
  input  logic             ctl_valid,
  input  logic             ctl_write,
  input  logic [SZ_W-1:0]  ctl_size,
  input  logic [15:0]      ctl_wdata,
  input  logic             dat_valid,
  input  logic             dat_write,
  input  logic [2:0]       dat_addr,
  input  logic [SZ_W-1:0]  dat_size,
  input  logic             pl_byte_we,
  input  logic             pl_len_we,
  input  logic             pl_bank,
  input  logic [IDX_W-1:0] pl_entry,
  input  logic [BA_W-1:0]  pl_addr,
  input  logic [7:0]       pl_data,
  input  logic [OFF_W-1:0] pl_len,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rej
);
  localparam int ROWS   = 2 * LIMIT;
  localparam int ROW_AW = $clog2(ROWS);
  localparam int MEM_AW = $clog2(ROWS * MAX_LEN);

  logic [7:0]       mem   [ROWS*MAX_LEN];
  logic [OFF_W-1:0] len_q [ROWS];

  logic             cur_ok, cur_bank;
  logic [IDX_W-1:0] cur_idx;
  logic [OFF_W-1:0] off;

  logic        sel, rdq, bad, wr;
  logic [15:0] key;
  int          n, row, ilen, avail, take, pl_row;
  logic [DW-1:0] rv;
  logic        unused_keybit;

  assign unused_keybit = key[14];
  assign pl_row = int'(pl_bank) * LIMIT + int'(pl_entry);

  always_comb begin
    sel = 1'b0; rdq = 1'b0; bad = 1'b0; wr = 1'b0; key = '0; n = 1;
    if (cmb_valid) begin
      wr = cmb_write;
      if (cmb_size == 1) rdq = !cmb_write;
      else if (cmb_size == 2 && cmb_write) begin sel = 1'b1; key = cmb_wdata; end
      else bad = 1'b1;
    end else if (ctl_valid) begin
      wr = ctl_write;
      if (ctl_write && ctl_size == 2) begin sel = 1'b1; key = ctl_wdata; end
      else bad = 1'b1;
    end else if (dat_valid) begin
      wr = dat_write;
      if (dat_addr == 3'd0 && dat_size != 0 && int'(dat_size) <= RD_BYTES) begin
        rdq = !dat_write;
        n   = int'(dat_size);
      end else bad = 1'b1;
    end
  end

  always_comb begin
    row   = int'(cur_bank) * LIMIT + int'(cur_idx);
    ilen  = int'(len_q[ROW_AW'(row)]);
    avail = (cur_ok && int'(off) < ilen) ? ilen - int'(off) : 0;
    take  = (n < avail) ? n : avail;
    rv    = '0;
    for (int i = 0; i < RD_BYTES; i++)
      if (i < take)
        rv = rv | (DW'(mem[MEM_AW'(row * MAX_LEN + int'(off) + i)]) << (8 * (n - 1 - i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ok   <= 1'b1;
      cur_bank <= 1'b0;
      cur_idx  <= '0;
      off      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rej      <= 1'b0;
      for (int r = 0; r < ROWS; r++) len_q[ROW_AW'(r)] <= (r == 0) ? OFF_W'(4) : '0;
    end else begin
      rd_valid <= rdq || (bad && !wr);
      rd_data  <= rdq ? rv : '0;
      rej      <= bad;
      if (sel) begin
        cur_ok   <= int'(key[13:0]) < LIMIT;
        cur_bank <= key[15];
        cur_idx  <= key[IDX_W-1:0];
        off      <= '0;
      end else if (rdq) begin
        off <= off + OFF_W'(take);
      end
      if (pl_len_we && pl_row < ROWS) len_q[ROW_AW'(pl_row)] <= pl_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= 8'h51;
      mem[1] <= 8'h45;
      mem[2] <= 8'h4D;
      mem[3] <= 8'h55;
    end else if (pl_byte_we && pl_row < ROWS) begin
      mem[MEM_AW'(pl_row * MAX_LEN + int'(pl_addr))] <= pl_data;
    end
  end
endmodule

module cfg_item_port_chk #(
  parameter int SZ_W    = 4,
  parameter int OFF_W   = 5,
  parameter int DW      = 64,
  parameter int MAX_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmb_valid,
  input logic             cmb_write,
  input logic [SZ_W-1:0]  cmb_size,
  input logic             ctl_valid,
  input logic             ctl_write,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data,
  input logic             rej,
  input logic             cur_ok,
  input logic [OFF_W-1:0] off
);
  a_r2_select_clears_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_valid && cmb_write && cmb_size == 2) |=> (off == '0));

  a_r4_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(off) <= MAX_LEN);

  a_r6_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(cur_ok)) |-> (rd_data == '0));

  a_r7_wide_cmb_read_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_valid && !cmb_write && cmb_size == 2) |=> (rej && rd_valid && rd_data == '0));

  a_r8_ctl_read_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_write && !cmb_valid) |=> rej);

  a_r9_reject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rej && rd_valid) |-> (rd_data == '0));

  a_r9_reject_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> (off == $past(off)));
endmodule

bind cfg_item_port cfg_item_port_chk #(
  .SZ_W(SZ_W), .OFF_W(OFF_W), .DW(DW), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmb_valid(cmb_valid), .cmb_write(cmb_write),
  .cmb_size(cmb_size), .ctl_valid(ctl_valid), .ctl_write(ctl_write),
  .rd_valid(rd_valid), .rd_data(rd_data), .rej(rej), .cur_ok(cur_ok), .off(off)
);

// File: tb/tb_cfg_item_port.sv
module tb_cfg_item_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmb_valid = 0, cmb_write = 0, ctl_valid = 0, ctl_write = 0, dat_valid = 0, dat_write = 0;
  logic [3:0] cmb_size = 0, ctl_size = 0, dat_size = 0;
  logic [15:0] cmb_wdata = 0, ctl_wdata = 0;
  logic [2:0] dat_addr = 0;
  logic pl_byte_we = 0, pl_len_we = 0, pl_bank = 0;
  logic [2:0] pl_entry = 0;
  logic [3:0] pl_addr = 0;
  logic [7:0] pl_data = 0;
  logic [4:0] pl_len = 0;
  logic rd_valid, rej;
  logic [63:0] rd_data;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cfg_item_port dut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ifc: 0 combined, 1 control, 2 data
  task automatic acc(input int ifc, input logic wr, input int sz, input logic [15:0] d,
                     input int addr, output logic [63:0] q, output logic rv, output logic rj);
    @(negedge clk);
    case (ifc)
      0: begin cmb_valid = 1; cmb_write = wr; cmb_size = 4'(sz); cmb_wdata = d; end
      1: begin ctl_valid = 1; ctl_write = wr; ctl_size = 4'(sz); ctl_wdata = d; end
      default: begin dat_valid = 1; dat_write = wr; dat_size = 4'(sz); dat_addr = 3'(addr); end
    endcase
    @(negedge clk);
    q = rd_data; rv = rd_valid; rj = rej;
    cmb_valid = 0; ctl_valid = 0; dat_valid = 0;
  endtask

  task automatic sel(input int ifc, input logic [15:0] k, input string tag);
    logic [63:0] q; logic rv, rj;
    acc(ifc, 1, 2, k, 0, q, rv, rj);
    chk({tag, " select accepted"}, {63'd0, rj}, 64'd0);
  endtask

  task automatic rd(input int n, output logic [63:0] q);
    logic rv, rj;
    acc(2, 0, n, 16'd0, 0, q, rv, rj);
  endtask

  task automatic pl_item(input logic b, input int e, input logic [7:0] b0, input int len);
    @(negedge clk);
    pl_bank = b; pl_entry = 3'(e);
    for (int i = 0; i < len; i++) begin
      pl_byte_we = 1; pl_addr = 4'(i); pl_data = b0 + 8'(i);
      @(negedge clk);
    end
    pl_byte_we = 0; pl_len_we = 1; pl_len = 5'(len);
    @(negedge clk);
    pl_len_we = 0;
  endtask

  task automatic t_reset;
    logic [63:0] q; logic rv, rj;
    chk("R1 reset rd_valid", {63'd0, rd_valid}, 0);
    chk("R1 reset rej", {63'd0, rej}, 0);
    acc(0, 0, 1, 0, 0, q, rv, rj); chk("R1 sig byte0", q, 64'h51);
    chk("R11 rd_valid after read", {63'd0, rv}, 1);
    acc(0, 0, 1, 0, 0, q, rv, rj); chk("R1 sig byte1", q, 64'h45);
    rd(2, q); chk("R1 sig bytes2-3", q, 64'h4D55);
    rd(1, q); chk("R6 read past end", q, 0);
    sel(1, 16'h0000, "R2");
    rd(4, q); chk("R2 R1 reselect sig word", q, 64'h51454D55);
  endtask

  task automatic t_pack;
    logic [63:0] q;
    sel(1, 16'h0001, "R4");
    rd(2, q); chk("R4 two byte pack", q, 64'hA1A2);
    rd(4, q); chk("R5 zero fill right", q, 64'hA3000000);
    rd(1, q); chk("R6 offset at length", q, 0);
    sel(0, 16'h0001, "R2");
    rd(1, q); chk("R2 reselect restarts", q, 64'hA1);
  endtask

  task automatic t_bank;
    logic [63:0] q;
    sel(0, 16'h8001, "R3");
    rd(8, q); chk("R3 arch bank eight byte", q, 64'hB1B2B3B4B5000000);
    sel(0, 16'h4001, "R3");
    rd(1, q); chk("R3 bit14 ignored", q, 64'hA1);
  endtask

  task automatic t_invalid;
    logic [63:0] q;
    sel(0, 16'h0008, "R3");
    rd(4, q); chk("R3 R6 invalid key reads zero", q, 0);
    sel(1, 16'h3FFF, "R3");
    rd(1, q); chk("R6 large index reads zero", q, 0);
    sel(0, 16'h0007, "R6");
    rd(1, q); chk("R6 empty entry reads zero", q, 0);
  endtask

  task automatic t_cmb_reject;
    logic [63:0] q; logic rv, rj;
    sel(0, 16'h0001, "R7");
    rd(1, q); chk("R7 first byte", q, 64'hA1);
    acc(0, 0, 2, 0, 0, q, rv, rj);
    chk("R7 R9 size2 read rej", {62'd0, rj, rv}, 64'd3);
    chk("R9 rejected read data", q, 0);
    acc(0, 1, 4, 16'h8001, 0, q, rv, rj); chk("R7 size4 write rej", {63'd0, rj}, 1);
    acc(0, 0, 1, 0, 0, q, rv, rj); chk("R9 state kept after rejects", q, 64'hA2);
  endtask

  task automatic t_split_reject;
    logic [63:0] q; logic rv, rj;
    acc(1, 0, 2, 0, 0, q, rv, rj); chk("R8 ctl read rej", {63'd0, rj}, 1);
    acc(1, 1, 1, 16'h8001, 0, q, rv, rj); chk("R8 ctl byte write rej", {63'd0, rj}, 1);
    acc(2, 0, 1, 0, 1, q, rv, rj);
    chk("R8 data addr1 rej", {62'd0, rj, rv}, 64'd3);
    chk("R9 data addr1 zero", q, 0);
    acc(2, 0, 0, 0, 0, q, rv, rj); chk("R8 data size0 rej", {63'd0, rj}, 1);
    rd(1, q); chk("R9 offset kept after split rejects", q, 64'hA3);
  endtask

  task automatic t_writes_ignored;
    logic [63:0] q; logic rv, rj;
    sel(0, 16'h8001, "R8");
    acc(0, 1, 1, 16'h00FF, 0, q, rv, rj); chk("R7 byte write accepted", {62'd0, rj, rv}, 0);
    acc(2, 1, 1, 0, 0, q, rv, rj); chk("R8 data write accepted", {62'd0, rj, rv}, 0);
    rd(2, q); chk("R8 writes had no effect", q, 64'hB1B2);
  endtask

  task automatic t_priority;
    logic [63:0] q;
    @(negedge clk);
    cmb_valid = 1; cmb_write = 1; cmb_size = 2; cmb_wdata = 16'h0001;
    ctl_valid = 1; ctl_write = 1; ctl_size = 2; ctl_wdata = 16'h8001;
    @(negedge clk);
    chk("R10 no rejection on overlap", {63'd0, rej}, 0);
    cmb_valid = 0; ctl_valid = 0;
    rd(1, q); chk("R10 combined port served", q, 64'hA1);
    @(negedge clk);
    ctl_valid = 1; ctl_write = 1; ctl_size = 2; ctl_wdata = 16'h8001;
    dat_valid = 1; dat_write = 0; dat_size = 1; dat_addr = 0;
    @(negedge clk);
    chk("R10 data dropped under control", {63'd0, rd_valid}, 0);
    ctl_valid = 0; dat_valid = 0;
    rd(1, q); chk("R10 control served", q, 64'hB1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    pl_item(0, 1, 8'hA1, 3);   // R11 preload
    pl_item(1, 1, 8'hB1, 5);
    t_pack;
    t_bank;
    t_invalid;
    t_cmb_reject;
    t_split_reject;
    t_writes_ignored;
    t_priority;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule